// File: doc/BRIEF.md
# Cascadable Display Bit-RAM Write Addresser

This block sits behind a serial-bus command decoder and turns a stream of already decoded display commands and data bytes into writes into a display bit RAM. The RAM has 32 columns and 4 rows. A load-pointer command selects the starting column. A device-select command loads a small counter that names the device the following bytes are meant for. Each data byte is then spread over one or more columns, depending on how many rows the current drive mode uses. After every byte the pointer moves past the columns that byte covered.

Several copies of the block can share one command stream. Each copy has its own strapped 3-bit address. Every copy tracks the pointer and the device counter for every byte, but only the copy whose counter equals its strap stores the byte. When the pointer runs past the last column, the counter steps on. A long burst therefore continues into the next device in the chain without a new select command. If a transfer is cut short, the pointer is treated as unknown until it is loaded again. A combinational read port returns one column of the RAM.

Top module: `disp_ram_addresser`

## Requirements
- R1: After a synchronous active-low reset the pointer is 0, the device counter is 0, the pointer-valid flag is 1 and every RAM bit is 0.
- R2: A load-pointer command sets the pointer to its value and sets the pointer-valid flag. The next accepted byte starts at that column.
- R3: Byte bits are placed MSB first and column-major. Bit 7-k goes to column ptr+k/R, row k%R. R is the row count for the mode: drive_mode_i 0 gives 1 row (static), 1 gives 2, 2 gives 3 and 3 gives 4. In the 3-row mode, the last two bits land in rows 0 and 1 of the third column.
- R4: After each accepted byte the pointer advances by 8, 4, 3 or 2 for drive_mode_i 0, 1, 2 or 3 respectively.
- R5: A device-select command loads the device counter with its 3-bit value.
- R6: A byte is stored only when the device counter equals hw_subaddr_i as sampled in the byte's cycle. On a mismatch the RAM is unchanged, but the pointer and counter advance exactly as for a stored byte.
- R7: When pointer plus step exceeds 31, the pointer wraps modulo 32 and the device counter increments once, modulo 8. Bits of that byte that would fall beyond column 31 are dropped.
- R8: A transfer-abort strobe clears the pointer-valid flag. While the flag is clear, bytes are ignored: there is no write and no pointer or counter change. The next load-pointer command sets the flag again.
- R9: A data byte presented in the same cycle as a load-pointer, device-select or abort strobe is discarded. Abort has priority over both commands.
- R10: rd_data_o bit r shows row r of the column addressed by rd_col_i, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptr_load_i | input | 1 | Load-pointer command strobe |
| ptr_value_i | input | 5 | Column value for the load-pointer command |
| dev_sel_i | input | 1 | Device-select command strobe |
| dev_sel_value_i | input | 3 | Value for the device counter |
| byte_valid_i | input | 1 | Data byte strobe |
| byte_data_i | input | 8 | Data byte |
| xfer_abort_i | input | 1 | Bus transfer ended early |
| drive_mode_i | input | 2 | Rows per column minus one (0 static … 3 four rows) |
| hw_subaddr_i | input | 3 | Strapped device address |
| rd_col_i | input | 5 | Read-port column |
| rd_data_o | output | 4 | Row bits of the read column |
| ptr_o | output | 5 | Current pointer |
| ptr_valid_o | output | 1 | Pointer is defined |
| subaddr_cnt_o | output | 3 | Current device counter |

## Verification
The hardest state to reach is a burst that overflows the pointer partway through a byte. That byte must lose its tail bits, and the counter step must then hand ownership to the neighbouring device, which is visible only in a second instance. The bench builds this with two instances strapped to 0 and 1 on shared inputs. It loads the pointer near column 31 in several modes and follows the overflowing byte with another one, so that the write shows up in the other RAM. A further case selects counter 7 and overflows, so the counter wraps to 0 while neither device stores anything.

// File: rtl/disp_addr_pkg.sv
`timescale 1ns/1ps
// Package: shared drive-mode type and per-mode geometry helpers.
// Assumes the RAM has four rows; the mode code equals rows-per-column minus one.
package disp_addr_pkg;

    typedef enum logic [1:0] {
        MODE_STATIC = 2'd0,
        MODE_ROWS2  = 2'd1,
        MODE_ROWS3  = 2'd2,
        MODE_ROWS4  = 2'd3
    } drive_mode_e;

    // Rows of one column that a byte fills in the given mode.
    function automatic logic [2:0] rows_for(drive_mode_e m);
        return {1'b0, m} + 3'd1;
    endfunction

    // Columns one byte occupies (ceil(8/rows)), i.e. the pointer step.
    function automatic logic [3:0] step_for(drive_mode_e m);
        case (m)
            MODE_STATIC: return 4'd8;
            MODE_ROWS2:  return 4'd4;
            MODE_ROWS3:  return 4'd3;
            default:     return 4'd2;
        endcase
    endfunction

endpackage

// File: rtl/disp_addr_ctrl.sv
`timescale 1ns/1ps
// Module: pointer, device counter and pointer-valid tracking.
// Decides per cycle whether a byte is accepted and whether this device stores it.
// Assumes the step never exceeds COLS, so one subtraction wraps the sum.
module disp_addr_ctrl #(
    parameter int COLS  = 32,
    parameter int SUB_W = 3,
    localparam int PTR_W = $clog2(COLS),
    localparam int SUM_W = PTR_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_load_i,
    input  logic [PTR_W-1:0] ptr_value_i,
    input  logic             dev_sel_i,
    input  logic [SUB_W-1:0] dev_sel_value_i,
    input  logic             byte_valid_i,
    input  logic             abort_i,
    input  logic [3:0]       step_i,
    input  logic [SUB_W-1:0] hw_sub_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic [SUB_W-1:0] sub_cnt_o,
    output logic             ptr_valid_o,
    output logic             byte_accept_o,
    output logic             write_sel_o
);

    logic [SUM_W-1:0] sum;
    logic             ovf;
    logic [PTR_W-1:0] ptr_next;

    // Accept a byte only when no command shares its cycle and the pointer is known.
    always_comb begin
        byte_accept_o = byte_valid_i && ptr_valid_o && !ptr_load_i && !dev_sel_i && !abort_i;
        write_sel_o   = byte_accept_o && (sub_cnt_o == hw_sub_i);
    end

    // Pointer plus step, with wrap and overflow detection.
    always_comb begin
        sum      = SUM_W'(ptr_o) + SUM_W'(step_i);
        ovf      = sum > SUM_W'(COLS - 1);
        ptr_next = ovf ? PTR_W'(sum - SUM_W'(COLS)) : PTR_W'(sum);
    end

    // Register update: abort first, then commands, then byte advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_o       <= '0;
            sub_cnt_o   <= '0;
            ptr_valid_o <= 1'b1;
        end else if (abort_i) begin
            ptr_valid_o <= 1'b0;
        end else begin
            if (ptr_load_i) begin
                ptr_o       <= ptr_value_i;
                ptr_valid_o <= 1'b1;
            end
            if (dev_sel_i) begin
                sub_cnt_o <= dev_sel_value_i;
            end
            if (byte_accept_o) begin
                ptr_o <= ptr_next;
                if (ovf) begin
                    sub_cnt_o <= sub_cnt_o + 1'b1;
                end
            end
        end
    end

    // R4
    step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_accept_o |=> int'(ptr_o) == (int'($past(ptr_o)) + int'($past(step_i))) % COLS);

    // R7
    carry_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_accept_o && (int'(ptr_o) + int'(step_i) >= COLS))
        |=> sub_cnt_o == $past(sub_cnt_o) + 1'b1);

    // R8
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !ptr_valid_o);

    // R8
    invalid_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_valid_o && !ptr_load_i && !dev_sel_i) |=> ($stable(ptr_o) && $stable(sub_cnt_o)));

endmodule

// File: rtl/disp_byte_scatter.sv
`timescale 1ns/1ps
// Module: maps one byte onto per-cell write masks and data for the whole RAM.
// Bit 7-k goes to column ptr+k/rows, row k%rows; cells past the last column get nothing.
// Purely combinational; one small decode per RAM cell.
module disp_byte_scatter #(
    parameter int COLS   = 32,
    parameter int ROWS   = 4,
    parameter int BYTE_W = 8,
    localparam int PTR_W = $clog2(COLS)
) (
    input  logic                        enable_i,
    input  logic [PTR_W-1:0]            ptr_i,
    input  logic [2:0]                  rows_i,
    input  logic [BYTE_W-1:0]           data_i,
    output logic [COLS-1:0][ROWS-1:0]   wr_mask_o,
    output logic [COLS-1:0][ROWS-1:0]   wr_data_o
);

    for (genvar c = 0; c < COLS; c++) begin : g_col
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            logic m_bit;
            logic d_bit;

            // Decide whether this cell receives a bit of the byte and which one.
            always_comb begin
                int off;
                int k;
                logic [BYTE_W-1:0] shifted;
                off     = c - int'(ptr_i);
                k       = off * int'(rows_i) + r;
                shifted = data_i << k;
                m_bit   = 1'b0;
                d_bit   = 1'b0;
                if (enable_i && off >= 0 && r < int'(rows_i) && k < BYTE_W) begin
                    m_bit = 1'b1;
                    d_bit = shifted[BYTE_W-1];
                end
            end

            assign wr_mask_o[c][r] = m_bit;
            assign wr_data_o[c][r] = d_bit;
        end
    end

endmodule

// File: rtl/disp_bit_ram.sv
`timescale 1ns/1ps
// Module: column x row bit storage with per-bit write mask and a combinational column read.
// Assumes the read column is below COLS; reset clears every bit.
module disp_bit_ram #(
    parameter int COLS = 32,
    parameter int ROWS = 4,
    localparam int PTR_W = $clog2(COLS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [COLS-1:0][ROWS-1:0] wr_mask_i,
    input  logic [COLS-1:0][ROWS-1:0] wr_data_i,
    input  logic [PTR_W-1:0]          rd_col_i,
    output logic [ROWS-1:0]           rd_data_o
);

    logic [COLS-1:0][ROWS-1:0] mem;

    // Masked bit update of the storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else begin
            mem <= (mem & ~wr_mask_i) | (wr_data_i & wr_mask_i);
        end
    end

    // Column read, no clock delay.
    assign rd_data_o = mem[rd_col_i];

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask_i == '0) |=> $stable(mem));

endmodule

// File: rtl/disp_ram_addresser.sv
`timescale 1ns/1ps
// Top: cascadable display RAM write addresser.
// Joins the pointer/counter control, the byte scatter and the bit RAM.
// Assumes command and byte strobes are single-cycle pulses from the decoder.
module disp_ram_addresser
    import disp_addr_pkg::*;
#(
    parameter int COLS   = 32,
    parameter int ROWS   = 4,
    parameter int SUB_W  = 3,
    parameter int BYTE_W = 8,
    localparam int PTR_W = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_load_i,
    input  logic [PTR_W-1:0]  ptr_value_i,
    input  logic              dev_sel_i,
    input  logic [SUB_W-1:0]  dev_sel_value_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_data_i,
    input  logic              xfer_abort_i,
    input  logic [1:0]        drive_mode_i,
    input  logic [SUB_W-1:0]  hw_subaddr_i,
    input  logic [PTR_W-1:0]  rd_col_i,
    output logic [ROWS-1:0]   rd_data_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              ptr_valid_o,
    output logic [SUB_W-1:0]  subaddr_cnt_o
);

    drive_mode_e               mode;
    logic [3:0]                step;
    logic [2:0]                rows;
    logic                      byte_accept;
    logic                      write_sel;
    logic [COLS-1:0][ROWS-1:0] wr_mask;
    logic [COLS-1:0][ROWS-1:0] wr_data;

    // Mode geometry for the current byte.
    always_comb begin
        mode = drive_mode_e'(drive_mode_i);
        step = step_for(mode);
        rows = rows_for(mode);
    end

    disp_addr_ctrl #(
        .COLS  (COLS),
        .SUB_W (SUB_W)
    ) i_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .ptr_load_i      (ptr_load_i),
        .ptr_value_i     (ptr_value_i),
        .dev_sel_i       (dev_sel_i),
        .dev_sel_value_i (dev_sel_value_i),
        .byte_valid_i    (byte_valid_i),
        .abort_i         (xfer_abort_i),
        .step_i          (step),
        .hw_sub_i        (hw_subaddr_i),
        .ptr_o           (ptr_o),
        .sub_cnt_o       (subaddr_cnt_o),
        .ptr_valid_o     (ptr_valid_o),
        .byte_accept_o   (byte_accept),
        .write_sel_o     (write_sel)
    );

    disp_byte_scatter #(
        .COLS   (COLS),
        .ROWS   (ROWS),
        .BYTE_W (BYTE_W)
    ) i_scatter (
        .enable_i  (write_sel),
        .ptr_i     (ptr_o),
        .rows_i    (rows),
        .data_i    (byte_data_i),
        .wr_mask_o (wr_mask),
        .wr_data_o (wr_data)
    );

    disp_bit_ram #(
        .COLS (COLS),
        .ROWS (ROWS)
    ) i_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mask_i (wr_mask),
        .wr_data_i (wr_data),
        .rd_col_i  (rd_col_i),
        .rd_data_o (rd_data_o)
    );

    // R6
    mismatch_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_accept && (subaddr_cnt_o != hw_subaddr_i)) |-> (wr_mask == '0));

    // R3
    mask_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_mask) <= BYTE_W);

    // R9
    cmd_blocks_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_load_i || dev_sel_i || xfer_abort_i) |-> (wr_mask == '0));

endmodule

// File: tb/test_disp_ram_addresser.sv
`timescale 1ns/1ps
// Directed bench: two instances strapped 0 and 1 on shared inputs, against a bench model.
module test_disp_ram_addresser;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ptr_load = 1'b0;
    logic [4:0] ptr_value = '0;
    logic       dev_sel = 1'b0;
    logic [2:0] dev_sel_value = '0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       xfer_abort = 1'b0;
    logic [1:0] drive_mode = '0;
    logic [4:0] rd_col = '0;

    logic [3:0] rd_data [2];
    logic [4:0] ptr_out [2];
    logic       valid_out [2];
    logic [2:0] sub_out [2];

    int checks = 0;
    int errors = 0;

    // Reference model state per device.
    logic [4:0] m_ptr [2];
    logic [2:0] m_sub [2];
    logic       m_valid [2];
    logic [3:0] m_mem [2][32];
    logic [2:0] strap [2];

    always #4 clk = ~clk;

    disp_ram_addresser i_disp_ram_addresser (
        .clk(clk), .rst_n(rst_n), .ptr_load_i(ptr_load), .ptr_value_i(ptr_value),
        .dev_sel_i(dev_sel), .dev_sel_value_i(dev_sel_value), .byte_valid_i(byte_valid),
        .byte_data_i(byte_data), .xfer_abort_i(xfer_abort), .drive_mode_i(drive_mode),
        .hw_subaddr_i(3'd0), .rd_col_i(rd_col), .rd_data_o(rd_data[0]),
        .ptr_o(ptr_out[0]), .ptr_valid_o(valid_out[0]), .subaddr_cnt_o(sub_out[0]));

    disp_ram_addresser i_disp_ram_addresser_dev1 (
        .clk(clk), .rst_n(rst_n), .ptr_load_i(ptr_load), .ptr_value_i(ptr_value),
        .dev_sel_i(dev_sel), .dev_sel_value_i(dev_sel_value), .byte_valid_i(byte_valid),
        .byte_data_i(byte_data), .xfer_abort_i(xfer_abort), .drive_mode_i(drive_mode),
        .hw_subaddr_i(3'd1), .rd_col_i(rd_col), .rd_data_o(rd_data[1]),
        .ptr_o(ptr_out[1]), .ptr_valid_o(valid_out[1]), .subaddr_cnt_o(sub_out[1]));

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        summary();
    end

    task automatic model_reset();
        for (int d = 0; d < 2; d++) begin
            m_ptr[d] = '0; m_sub[d] = '0; m_valid[d] = 1'b1;
            for (int c = 0; c < 32; c++) m_mem[d][c] = '0;
        end
    endtask

    // Model of one byte arriving at both devices (R3 R4 R6 R7 R8).
    task automatic model_byte(input logic [7:0] data);
        int rows, step, col, sum;
        rows = int'(drive_mode) + 1;
        step = (rows == 1) ? 8 : (rows == 2) ? 4 : (rows == 3) ? 3 : 2;
        for (int d = 0; d < 2; d++) begin
            if (m_valid[d]) begin
                if (m_sub[d] == strap[d]) begin
                    for (int k = 0; k < 8; k++) begin
                        col = int'(m_ptr[d]) + k / rows;
                        if (col < 32) m_mem[d][col][k % rows] = data[7 - k];
                    end
                end
                sum = int'(m_ptr[d]) + step;
                if (sum > 31) begin
                    m_sub[d] = m_sub[d] + 3'd1;
                    sum = sum - 32;
                end
                m_ptr[d] = 5'(sum);
            end
        end
    endtask

    task automatic do_load(input logic [4:0] v);
        @(negedge clk); ptr_load = 1'b1; ptr_value = v;
        @(negedge clk); ptr_load = 1'b0;
        for (int d = 0; d < 2; d++) begin m_ptr[d] = v; m_valid[d] = 1'b1; end
    endtask

    task automatic do_sel(input logic [2:0] v);
        @(negedge clk); dev_sel = 1'b1; dev_sel_value = v;
        @(negedge clk); dev_sel = 1'b0;
        for (int d = 0; d < 2; d++) m_sub[d] = v;
    endtask

    task automatic do_byte(input logic [1:0] mode, input logic [7:0] data);
        @(negedge clk); drive_mode = mode; byte_valid = 1'b1; byte_data = data;
        @(negedge clk); byte_valid = 1'b0;
        model_byte(data);
    endtask

    task automatic do_abort();
        @(negedge clk); xfer_abort = 1'b1;
        @(negedge clk); xfer_abort = 1'b0;
        for (int d = 0; d < 2; d++) m_valid[d] = 1'b0;
    endtask

    task automatic chk_regs(input string req);
        for (int d = 0; d < 2; d++) begin
            checks++;
            if (ptr_out[d] !== m_ptr[d] || sub_out[d] !== m_sub[d] || valid_out[d] !== m_valid[d]) begin
                errors++;
                $display("FAIL %s dev%0d: ptr/sub/valid actual %0d/%0d/%0b expected %0d/%0d/%0b",
                         req, d, ptr_out[d], sub_out[d], valid_out[d], m_ptr[d], m_sub[d], m_valid[d]);
            end
        end
    endtask

    task automatic chk_ram(input string req);
        for (int d = 0; d < 2; d++) begin
            int bad;
            bad = 0;
            checks++;
            for (int c = 0; c < 32; c++) begin
                rd_col = 5'(c);
                #1;
                if (bad == 0 && rd_data[d] !== m_mem[d][c]) begin
                    bad = 1;
                    errors++;
                    $display("FAIL %s dev%0d col%0d: actual %b expected %b",
                             req, d, c, rd_data[d], m_mem[d][c]);
                end
            end
        end
    endtask

    // R1 R10: reset state.
    task automatic t_reset();
        chk_regs("R1");
        chk_ram("R1 R10");
    endtask

    // R2 R3 R4 R6: static byte to device 0, device 1 still advances.
    task automatic t_static();
        do_sel(3'd0);
        do_load(5'd4);
        do_byte(2'd0, 8'hA5);
        chk_regs("R2 R4 R6");
        chk_ram("R3 R6");
    endtask

    // R3 R4: 2-, 3- and 4-row packings back to back.
    task automatic t_modes();
        do_load(5'd0);
        do_byte(2'd1, 8'h3C);
        chk_regs("R4 2-row");
        do_byte(2'd2, 8'hF0);
        chk_regs("R4 3-row");
        do_byte(2'd3, 8'h96);
        chk_regs("R4 4-row");
        chk_ram("R3 modes");
    endtask

    // R7: overflow drops tail bits and hands the burst to device 1.
    task automatic t_overflow();
        do_load(5'd30);
        do_byte(2'd0, 8'hFF);
        chk_regs("R7 carry");
        do_byte(2'd0, 8'h81);
        chk_regs("R7 next");
        chk_ram("R7 cascade");
    endtask

    // R5 R7: select 7, overflow wraps the counter to 0 with no write anywhere.
    task automatic t_sub_wrap();
        do_sel(3'd7);
        chk_regs("R5");
        do_load(5'd31);
        do_byte(2'd3, 8'hC3);
        chk_regs("R7 wrap");
        chk_ram("R6 R7 wrap");
    endtask

    // R8: abort invalidates; bytes ignored until reload.
    task automatic t_abort();
        do_abort();
        chk_regs("R8 abort");
        @(negedge clk); drive_mode = 2'd0; byte_valid = 1'b1; byte_data = 8'hFF;
        @(negedge clk); byte_valid = 1'b0;
        chk_regs("R8 ignored");
        chk_ram("R8 ignored");
        do_load(5'd10);
        chk_regs("R8 reload");
    endtask

    // R9: byte beside a load or abort is discarded.
    task automatic t_priority();
        do_sel(3'd0);
        @(negedge clk); ptr_load = 1'b1; ptr_value = 5'd20; byte_valid = 1'b1; byte_data = 8'hFF;
        @(negedge clk); ptr_load = 1'b0; byte_valid = 1'b0;
        for (int d = 0; d < 2; d++) m_ptr[d] = 5'd20;
        chk_regs("R9 load");
        @(negedge clk); xfer_abort = 1'b1; ptr_load = 1'b1; ptr_value = 5'd3; byte_valid = 1'b1;
        @(negedge clk); xfer_abort = 1'b0; ptr_load = 1'b0; byte_valid = 1'b0;
        for (int d = 0; d < 2; d++) m_valid[d] = 1'b0;
        chk_regs("R9 abort");
        chk_ram("R9");
    endtask

    // R3 R7: 3-row byte on device 1 ending exactly at the last column.
    task automatic t_rows3_edge();
        do_sel(3'd1);
        do_load(5'd29);
        do_byte(2'd2, 8'hDB);
        chk_regs("R7 edge");
        chk_ram("R3 edge");
    endtask

    initial begin
        strap[0] = 3'd0;
        strap[1] = 3'd1;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_static();
        t_modes();
        t_overflow();
        t_sub_wrap();
        t_abort();
        t_priority();
        t_rows3_edge();
        summary();
    end

endmodule